// File: doc/BRIEF.md
# Low-Power Mode Controller for an 8-bit Microcontroller Core

This block decides when a small microcontroller core sleeps and when it wakes. Software writes a power-control register. One bit asks for idle, where the core clock stops and the peripherals keep running. Another bit asks for power-down, where the oscillator is turned off and everything stops. The controller drives three enables: one for the core clock, one for the peripheral clocks and one for the oscillator. It watches the interrupt lines, the per-source enables and the global enable so that it can end idle. It also watches the hardware reset pin, which is the only way out of power-down.

A hardware reset that arrives during idle does not take effect at once. The core runs on for a window of up to two machine cycles, each machine cycle being 12 oscillator clocks. During that window a RAM write inhibit is raised, so internal RAM cannot be corrupted. Port writes are not blocked. When the window ends, the internal core reset is asserted. It stays asserted until the reset pin is released, and then the core runs again with both mode bits cleared. The CPU, interrupt vectoring, the return-from-interrupt mechanics and the oscillator circuit lie outside the block. They appear only as the signals listed below.

Top module: `lpm_ctrl`

## Requirements
- R1: After the block reset `rst_n` is released, the core, peripheral and oscillator enables are 1, `ram_wr_inhibit` and `core_rst` are 0, and `reg_rdata` reads 0.
- R2: A register write with bit 0 (idle request) set, in the running state, gives `core_clk_en`=0 from the next cycle, with `periph_clk_en`=1 and `osc_en`=1. Bit 0 then reads back as 1.
- R3: In idle, the block wakes at a clock edge where `irq_gen`=1 and some `irq_req[i] & irq_en[i]` is 1. From the next cycle `core_clk_en`=1 and bit 0 reads 0. A request that is not enabled, or one seen while `irq_gen`=0, leaves the block idle.
- R4: A write with bit 1 (power-down request) set turns off all three enables from the next cycle. Interrupts of any kind leave them off; only `ext_rst` ends power-down.
- R5: A single write with both bit 0 and bit 1 set enters power-down, not idle.
- R6: `ext_rst` seen in idle starts a window of exactly 24 clocks (2 machine cycles of 12 clocks). In the window `core_clk_en`=1, `ram_wr_inhibit`=1 and `core_rst`=0. In the cycle after the window, `core_rst`=1 and `ram_wr_inhibit`=0.
- R7: `ext_rst` seen while running or in power-down gives `core_rst`=1 from the next cycle with no window (`ram_wr_inhibit` stays 0). A register write in the same cycle is dropped, and both mode bits read 0.
- R8: While `core_rst`=1, an edge with `ext_rst`=0 returns the block to running: all enables 1, `core_rst`=0, `reg_rdata`=0.
- R9: Register writes are accepted only in the running state. A power-down write during the reset window leaves `osc_en`=1, and both mode bits read 0.
- R10: Register bits other than bit 0 and bit 1 always read 0. A write with neither mode bit set leaves the block running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| ext_rst | input | 1 | Hardware reset pin, active high, sampled on clk |
| reg_wr | input | 1 | Power-control register write strobe |
| reg_wdata | input | 8 | Write data; bit 0 idle request, bit 1 power-down request |
| reg_rdata | output | 8 | Power-control register read value |
| irq_req | input | 5 | Interrupt request levels |
| irq_en | input | 5 | Per-source interrupt enables |
| irq_gen | input | 1 | Global interrupt enable |
| core_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes during the reset window |
| core_rst | output | 1 | Internal core reset |

## Verification
The assertions assume that `clk` keeps toggling while `osc_en` is low. This lets the model sample the reset pin in power-down, where real silicon would use an unclocked path. They also assume that `ext_rst` and the interrupt lines are synchronous to `clk`. The bench meets both assumptions. It runs a free clock the whole time and changes every input only on the falling edge. It holds `ext_rst` high at least until the internal reset has taken control, so the window-length check is always exercised end to end.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      LPM_RUN     = 3'd0,
      LPM_IDLE    = 3'd1,
      LPM_PDOWN   = 3'd2,
      LPM_RSTWIN  = 3'd3,
      LPM_RSTHOLD = 3'd4
   } lpm_state_e;

   typedef struct packed {
      logic core_en;
      logic periph_en;
      logic osc_en;
      logic ram_inh;
      logic core_rst;
   } lpm_outs_t;

   // Output pattern of every state, kept in one place
   function automatic lpm_outs_t lpm_decode(input lpm_state_e st);
      lpm_outs_t o;
      unique case (st)
         LPM_RUN:     o = '{core_en:1'b1, periph_en:1'b1, osc_en:1'b1, ram_inh:1'b0, core_rst:1'b0};
         LPM_IDLE:    o = '{core_en:1'b0, periph_en:1'b1, osc_en:1'b1, ram_inh:1'b0, core_rst:1'b0};
         LPM_PDOWN:   o = '{core_en:1'b0, periph_en:1'b0, osc_en:1'b0, ram_inh:1'b0, core_rst:1'b0};
         LPM_RSTWIN:  o = '{core_en:1'b1, periph_en:1'b1, osc_en:1'b1, ram_inh:1'b1, core_rst:1'b0};
         LPM_RSTHOLD: o = '{core_en:1'b1, periph_en:1'b1, osc_en:1'b1, ram_inh:1'b0, core_rst:1'b1};
         default:     o = '{core_en:1'b1, periph_en:1'b1, osc_en:1'b1, ram_inh:1'b0, core_rst:1'b1};
      endcase
      return o;
   endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
   parameter int NUM_IRQ     = 5,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic               irq_gen,
   output logic               wake
);

   logic wake_raw;

   initial begin
      if (NUM_IRQ < 1) $error("lpm_wake_qual: NUM_IRQ must be at least 1");
      if (SYNC_STAGES < 0) $error("lpm_wake_qual: SYNC_STAGES must not be negative");
   end

   // Level-sensitive qualification: any enabled source while globally enabled
   assign wake_raw = irq_gen & (|(irq_req & irq_en));

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign wake = wake_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= wake_raw;
               for (int s = 1; s < SYNC_STAGES; s++) begin
                  pipe_q[s] <= pipe_q[s-1];
               end
            end
         end
         assign wake = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg #(
   parameter int REG_W    = 8,
   parameter int IDLE_BIT = 0,
   parameter int PDN_BIT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic [REG_W-1:0] wdata,
   input  logic             clr_all,
   input  logic             clr_idle,
   output logic             idle_q,
   output logic             pdn_q,
   output logic [REG_W-1:0] rdata
);

   logic unused_wdata;

   initial begin
      if (IDLE_BIT == PDN_BIT) $error("lpm_mode_reg: mode bits must differ");
      if (IDLE_BIT >= REG_W || PDN_BIT >= REG_W) $error("lpm_mode_reg: mode bit outside register");
   end

   // Priority: reset clear, then wake clear, then software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= 1'b0;
         pdn_q  <= 1'b0;
      end else if (clr_all) begin
         idle_q <= 1'b0;
         pdn_q  <= 1'b0;
      end else if (clr_idle) begin
         idle_q <= 1'b0;
      end else if (wr_ok) begin
         idle_q <= wdata[IDLE_BIT];
         pdn_q  <= wdata[PDN_BIT];
      end
   end

   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_rd
         if (b == IDLE_BIT) begin : g_idle
            assign rdata[b] = idle_q;
         end else if (b == PDN_BIT) begin : g_pdn
            assign rdata[b] = pdn_q;
         end else begin : g_zero
            assign rdata[b] = 1'b0;
         end
      end
   endgenerate

   // Reserved bits of the write data carry no function
   assign unused_wdata = ^wdata;

endmodule

// File: rtl/lpm_rst_window.sv
module lpm_rst_window #(
   parameter int WIN_CLKS = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic active,
   output logic last
);

   localparam int CNT_W = (WIN_CLKS > 1) ? $clog2(WIN_CLKS) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WIN_CLKS - 1);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      if (WIN_CLKS < 1) $error("lpm_rst_window: WIN_CLKS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (active && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = active && (cnt_q == '0);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ext_rst,
   input  logic       wr_req,
   input  logic       wr_idle,
   input  logic       wr_pdn,
   input  logic       wake,
   input  logic       win_last,
   output logic       wr_ok,
   output logic       clr_all,
   output logic       clr_idle,
   output logic       win_load,
   output logic       win_active,
   output lpm_outs_t  outs
);

   lpm_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      win_load = 1'b0;
      clr_idle = 1'b0;
      unique case (state_q)
         LPM_RUN: begin
            if (ext_rst)                state_d = LPM_RSTHOLD;
            else if (wr_req && wr_pdn)  state_d = LPM_PDOWN;
            else if (wr_req && wr_idle) state_d = LPM_IDLE;
         end
         LPM_IDLE: begin
            if (ext_rst) begin
               state_d  = LPM_RSTWIN;
               win_load = 1'b1;
            end else if (wake) begin
               state_d  = LPM_RUN;
               clr_idle = 1'b1;
            end
         end
         LPM_PDOWN: begin
            if (ext_rst) state_d = LPM_RSTHOLD;
         end
         LPM_RSTWIN: begin
            if (win_last) state_d = LPM_RSTHOLD;
         end
         LPM_RSTHOLD: begin
            if (!ext_rst) state_d = LPM_RUN;
         end
         default: state_d = LPM_RSTHOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LPM_RUN;
      else        state_q <= state_d;
   end

   assign wr_ok      = wr_req && (state_q == LPM_RUN) && !ext_rst;
   assign clr_all    = ext_rst || (state_q == LPM_RSTWIN) || (state_q == LPM_RSTHOLD);
   assign win_active = (state_q == LPM_RSTWIN);
   assign outs       = lpm_decode(state_q);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int NUM_IRQ     = 5,
   parameter int REG_W       = 8,
   parameter int IDLE_BIT    = 0,
   parameter int PDN_BIT     = 1,
   parameter int MC_CLKS     = 12,
   parameter int WIN_MC      = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_rst,
   input  logic               reg_wr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic               irq_gen,
   output logic               core_clk_en,
   output logic               periph_clk_en,
   output logic               osc_en,
   output logic               ram_wr_inhibit,
   output logic               core_rst
);

   localparam int WIN_CLKS = MC_CLKS * WIN_MC;

   initial begin
      if (MC_CLKS < 1) $error("lpm_ctrl: MC_CLKS must be at least 1");
      if (WIN_MC < 1)  $error("lpm_ctrl: WIN_MC must be at least 1");
      if (REG_W < 2)   $error("lpm_ctrl: REG_W must hold both mode bits");
   end

   logic      wake, win_last, win_load, win_active;
   logic      wr_ok, clr_all, clr_idle;
   logic      idle_q, pdn_q;
   lpm_outs_t outs;

   lpm_wake_qual #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
      .irq_gen(irq_gen), .wake(wake)
   );

   lpm_mode_reg #(.REG_W(REG_W), .IDLE_BIT(IDLE_BIT), .PDN_BIT(PDN_BIT)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wdata(reg_wdata),
      .clr_all(clr_all), .clr_idle(clr_idle),
      .idle_q(idle_q), .pdn_q(pdn_q), .rdata(reg_rdata)
   );

   lpm_rst_window #(.WIN_CLKS(WIN_CLKS)) u_win (
      .clk(clk), .rst_n(rst_n), .load(win_load), .active(win_active), .last(win_last)
   );

   lpm_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
      .wr_req(reg_wr), .wr_idle(reg_wdata[IDLE_BIT]), .wr_pdn(reg_wdata[PDN_BIT]),
      .wake(wake), .win_last(win_last),
      .wr_ok(wr_ok), .clr_all(clr_all), .clr_idle(clr_idle),
      .win_load(win_load), .win_active(win_active), .outs(outs)
   );

   logic unused_modebits;
   assign unused_modebits = idle_q ^ pdn_q;

   assign core_clk_en    = outs.core_en;
   assign periph_clk_en  = outs.periph_en;
   assign osc_en         = outs.osc_en;
   assign ram_wr_inhibit = outs.ram_inh;
   assign core_rst       = outs.core_rst;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
   parameter int NUM_IRQ  = 5,
   parameter int REG_W    = 8,
   parameter int IDLE_BIT = 0,
   parameter int PDN_BIT  = 1,
   parameter int WIN_CLKS = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ext_rst,
   input logic               reg_wr,
   input logic [REG_W-1:0]   reg_rdata,
   input logic               core_clk_en,
   input logic               periph_clk_en,
   input logic               osc_en,
   input logic               ram_wr_inhibit,
   input logic               core_rst
);

   localparam int RUN_W = $clog2(WIN_CLKS + 2) + 1;
   logic [RUN_W-1:0] inh_run;

   // Length of the current stretch of inhibit cycles before this one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              inh_run <= '0;
      else if (ram_wr_inhibit) inh_run <= inh_run + 1'b1;
      else                     inh_run <= '0;
   end

   assert_pdn_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (!core_clk_en && !periph_clk_en));

   assert_pdn_only_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !ext_rst) |=> !osc_en);

   assert_idle_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_clk_en && periph_clk_en) |-> reg_rdata[IDLE_BIT]);

   assert_win_core_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_inhibit |-> (core_clk_en && osc_en && !core_rst));

   assert_win_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_inhibit |-> (inh_run < RUN_W'(WIN_CLKS)));

   assert_win_then_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_wr_inhibit && inh_run == RUN_W'(WIN_CLKS - 1)) |=> (core_rst && !ram_wr_inhibit));

   assert_rst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> (reg_rdata == '0));

   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst && !ext_rst) |=> (!core_rst && core_clk_en && osc_en));

   assert_no_write_in_win_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_wr_inhibit && reg_wr) |=> osc_en);

   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_rsv
         if (b != IDLE_BIT && b != PDN_BIT) begin : g_chk
            assert_rsv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
               !reg_rdata[b]);
         end
      end
   endgenerate

endmodule

bind lpm_ctrl lpm_ctrl_chk #(
   .NUM_IRQ(NUM_IRQ), .REG_W(REG_W), .IDLE_BIT(IDLE_BIT), .PDN_BIT(PDN_BIT),
   .WIN_CLKS(MC_CLKS * WIN_MC)
) u_lpm_chk (
   .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .reg_wr(reg_wr),
   .reg_rdata(reg_rdata), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
   .osc_en(osc_en), .ram_wr_inhibit(ram_wr_inhibit), .core_rst(core_rst)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;

   localparam int NIRQ = 5;
   localparam int WIN  = 12 * 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ext_rst = 1'b0;
   logic            reg_wr = 1'b0;
   logic [7:0]      reg_wdata = '0;
   logic [7:0]      reg_rdata;
   logic [NIRQ-1:0] irq_req = '0;
   logic [NIRQ-1:0] irq_en = '0;
   logic            irq_gen = 1'b0;
   logic            core_clk_en, periph_clk_en, osc_en, ram_wr_inhibit, core_rst;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lpm_ctrl i_lpm_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
      .irq_en(irq_en), .irq_gen(irq_gen), .core_clk_en(core_clk_en),
      .periph_clk_en(periph_clk_en), .osc_en(osc_en),
      .ram_wr_inhibit(ram_wr_inhibit), .core_rst(core_rst)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Packs the five control outputs: core, periph, osc, inhibit, core_rst
   function automatic int outs();
      return {core_clk_en, periph_clk_en, osc_en, ram_wr_inhibit, core_rst};
   endfunction

   localparam int O_RUN  = 5'b11100;
   localparam int O_IDLE = 5'b01100;
   localparam int O_PDN  = 5'b00000;
   localparam int O_WIN  = 5'b11110;
   localparam int O_HOLD = 5'b11101;

   task automatic write_reg(input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic pulse_reset_pin();
      @(negedge clk);
      ext_rst = 1'b1;
      @(negedge clk);
      ext_rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk("R1 outputs after reset", outs(), O_RUN);
      chk("R1 register after reset", reg_rdata, 0);
   endtask

   task automatic t_plain_write();
      write_reg(8'hFC);
      chk("R10 no mode bits keeps running", outs(), O_RUN);
      chk("R10 reserved bits read zero", reg_rdata, 0);
   endtask

   task automatic t_idle_wake();
      write_reg(8'h01);
      chk("R2 idle outputs", outs(), O_IDLE);
      chk("R2 idle bit reads one", reg_rdata, 1);
      irq_req = 5'b00100;
      irq_en  = 5'b11011;
      irq_gen = 1'b1;
      @(negedge clk);
      chk("R3 unenabled source keeps idle", outs(), O_IDLE);
      irq_en  = 5'b00100;
      irq_gen = 1'b0;
      @(negedge clk);
      chk("R3 global disable keeps idle", outs(), O_IDLE);
      irq_gen = 1'b1;
      @(negedge clk);
      chk("R3 enabled irq wakes", outs(), O_RUN);
      chk("R3 idle bit cleared on wake", reg_rdata, 0);
      irq_req = '0;
      irq_gen = 1'b0;
      irq_en  = '0;
   endtask

   task automatic t_pdown(input logic [7:0] d, input string req);
      write_reg(d);
      chk(req, outs(), O_PDN);
      irq_req = '1;
      irq_en  = '1;
      irq_gen = 1'b1;
      repeat (30) @(negedge clk);
      chk("R4 interrupts ignored in power-down", outs(), O_PDN);
      irq_req = '0;
      irq_en  = '0;
      irq_gen = 1'b0;
      @(negedge clk);
      ext_rst = 1'b1;
      @(negedge clk);
      chk("R7 reset from power-down no window", outs(), O_HOLD);
      chk("R7 bits cleared", reg_rdata, 0);
      ext_rst = 1'b0;
      @(negedge clk);
      chk("R8 release after power-down", outs(), O_RUN);
   endtask

   task automatic t_idle_reset_window();
      int n_win;
      bit osc_ok;
      write_reg(8'h01);
      chk("R2 idle before reset", outs(), O_IDLE);
      ext_rst = 1'b1;
      @(negedge clk);
      chk("R6 window outputs", outs(), O_WIN);
      reg_wr = 1'b1;
      reg_wdata = 8'h02;
      n_win = 0;
      osc_ok = 1'b1;
      while (ram_wr_inhibit && n_win < 100) begin
         n_win++;
         @(negedge clk);
         reg_wr = 1'b0;
         reg_wdata = '0;
         if (!osc_en) osc_ok = 1'b0;
      end
      chk("R6 window length", n_win, WIN);
      chk("R6 reset takes control after window", outs(), O_HOLD);
      chk("R9 write in window ignored", int'(osc_ok), 1);
      chk("R9 bits zero after window", reg_rdata, 0);
      ext_rst = 1'b0;
      @(negedge clk);
      chk("R8 release returns to run", outs(), O_RUN);
      chk("R8 register zero after release", reg_rdata, 0);
   endtask

   task automatic t_run_reset();
      @(negedge clk);
      ext_rst = 1'b1;
      reg_wr = 1'b1;
      reg_wdata = 8'h01;
      @(negedge clk);
      reg_wr = 1'b0;
      reg_wdata = '0;
      chk("R7 reset from run no window", outs(), O_HOLD);
      chk("R7 write with reset dropped", reg_rdata, 0);
      ext_rst = 1'b0;
      @(negedge clk);
      chk("R8 release from run reset", outs(), O_RUN);
      pulse_reset_pin();
      chk("R8 short pulse recovers", outs(), O_RUN);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_plain_write();
      t_idle_wake();
      t_pdown(8'h02, "R4 power-down outputs");
      t_pdown(8'h03, "R5 both bits give power-down");
      t_idle_reset_window();
      t_run_reset();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule